// File: doc/BRIEF.md
# Debug System Bus Access Master

This block gives a debug host a path into system memory. The host talks to it through a small word-wide register port: a control word, an address split over 32-bit words and a data value split over 32-bit words. Some register accesses start a memory transaction as a side effect. The transaction goes out on a generic request/response bus that allows one transaction in flight. Writing the low data word stores that data to memory. Writing an address word can start a load. Reading the low data word can step the address forward and fetch the next value. Together these let the host stream through memory with one register access per word.

Access widths run from one byte to sixteen bytes. The address can step forward by the access width on its own. A sticky error field records the first problem it sees: a bus timeout, an error response, a misaligned or unsupported request, or a register access that collides with a transaction in flight. While that field is non-zero the block starts no further transactions. A read of the low data word is refused when no new value has arrived since the last such read. The register port is combinational on the read side, so the host sees the data and a per-access error flag in the same cycle as its access.

Top module: `sba_master`

## Requirements
- R1: The control word (register 0x38) has these fields: bits [2:0] width code (reset 2), bit 3 step-after-access, bit 4 fetch-on-trigger, bit 5 one-shot load trigger (always reads 0), bits [8:6] error field (reset 0), bit 9 busy, bits [16:10] address width `ADDR_W`, bits [21:17] width-capability flags (bit 17+k set when code k fits `DATA_W`). Width code k means an access of 2^k bytes.
- R2: Address words live at 0x39 upward (32 bits each, low word first) and data words at 0x3C upward. Each one reads back what was last written to it, and the part of a word above `ADDR_W` reads 0.
- R3: Writing data word 0 (0x3C), while idle and with no error, raises exactly one write request. The request carries the current address, the width code and the stored data, including the upper data words that were written earlier. The request stays stable while it is held off.
- R4: With step-after-access set, the address grows by 2^code bytes after a data-word-0 write that issued its request. It also grows after every accepted data-word-0 read.
- R5: Writing 1 to control bit 5 issues one read at the current address, using the width code written in that same access. The returned data replaces the whole data register.
- R6: With fetch-on-trigger set, an accepted address-word write issues a read at the newly written address.
- R7: An accepted data-word-0 read returns the stored low word. With step-after-access set it then steps the address. With fetch-on-trigger set it then issues a read at the stepped address.
- R8: A data-word-0 read with no fresh data since the previous accepted read raises the access error flag and sets error 4. It changes neither the address nor the data, and issues no request. Data counts as fresh after a successful load or after a data-word-0 write.
- R9: While a transaction is in flight, an address or data write, a data-word-0 read or a one-shot trigger raises the access error flag, sets error 4 and is otherwise dropped.
- R10: A request whose address is not a multiple of 2^code bytes, or whose code is above 4 or wider than `DATA_W`, is not issued and sets error 3.
- R11: An error response sets error 2. A transaction with no response within `TIMEOUT_CYC` cycles of its trigger is dropped and sets error 1.
- R12: The error field keeps its first non-zero code and is cleared only by writing 1s to bits [8:6]. While it is non-zero, no request is issued, address and data writes are dropped, data-word-0 reads have no side effects, and all of these raise the access error flag.
- R13: Busy and the request are raised in the cycle after the triggering access. Busy falls, and loaded data appears, in the cycle after the edge that takes the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 7 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| reg_err | output | 1 | Current access is refused (combinational) |
| bus_req_valid | output | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted |
| bus_req_we | output | 1 | 1 = store, 0 = load |
| bus_req_addr | output | ADDR_W | Byte address |
| bus_req_size | output | 3 | Width code |
| bus_req_wdata | output | DATA_W | Store data |
| bus_rsp_valid | input | 1 | Response valid |
| bus_rsp_data | input | DATA_W | Load data |
| bus_rsp_err | input | 1 | Response reports an error |

## Verification
Register read data and the access error flag belong to the access cycle, so the bench samples them one time unit after driving, before the clock edge. Error codes, busy and address changes caused by an access appear after that access's edge, and the bench samples them from the next negative edge on. A triggered request is raised after the access edge and completes only after the responder's latency. The bench therefore polls busy until it falls before it checks memory or data. For the timeout, busy has to stay high through the edge `TIMEOUT_CYC-1` cycles after the trigger and be low, with error 1, after the next one. The bench counts edges to those two points and samples at each.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} sba_state_e;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_TIMEOUT = 3'd1;
  localparam logic [2:0] ERR_BADADDR = 3'd2;
  localparam logic [2:0] ERR_OTHER   = 3'd3;
  localparam logic [2:0] ERR_BUSY    = 3'd4;

  localparam logic [6:0] RA_CTL   = 7'h38;
  localparam logic [6:0] RA_ADDR0 = 7'h39;
  localparam logic [6:0] RA_DATA0 = 7'h3C;

  // bytes moved by one access of the given width code
  function automatic logic [7:0] width_bytes(input logic [2:0] code);
    return 8'(1) << code;
  endfunction

  // width code is legal for a data path of data_w bits
  function automatic logic width_ok(input logic [2:0] code, input int data_w);
    return (code <= 3'd4) && ((8 << code) <= data_w);
  endfunction

  // low address bits are a multiple of the access width
  function automatic logic addr_aligned(input logic [6:0] low, input logic [2:0] code);
    logic [6:0] mask;
    mask = 7'((8'(1) << code) - 8'(1));
    return (low & mask) == 7'd0;
  endfunction

  // capability flags, one per width code 0..4
  function automatic logic [4:0] width_caps(input int data_w);
    logic [4:0] c;
    for (int k = 0; k < 5; k++) c[k] = ((8 << k) <= data_w);
    return c;
  endfunction

endpackage

// File: rtl/sba_addr_reg.sv
module sba_addr_reg
  import sba_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int AW_WORDS = (ADDR_W + 31) / 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [31:0]       wr_word,
  input  logic              inc_en,
  input  logic [2:0]        inc_code,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_merged,
  output logic [ADDR_W-1:0] addr_stepped
);
  localparam int PAD_W = AW_WORDS * 32;

  logic [PAD_W-1:0] pad_now;
  logic [PAD_W-1:0] pad_new;

  always_comb begin
    pad_now = PAD_W'(addr_q);
    pad_new = pad_now;
    pad_new[wr_idx*32 +: 32] = wr_word;
    addr_merged  = pad_new[ADDR_W-1:0];
    addr_stepped = addr_q + ADDR_W'(width_bytes(inc_code));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (wr_en)  addr_q <= addr_merged;
    else if (inc_en) addr_q <= addr_stepped;
  end

endmodule

// File: rtl/sba_bus_engine.sv
module sba_bus_engine
  import sba_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int DATA_W      = 128,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        start_size,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        req_size,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              rd_done,
  output logic              fail,
  output logic [2:0]        fail_code
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  sba_state_e  state_q;
  logic [CNT_W-1:0] cnt_q;
  logic        timeout_hit;
  logic        rsp_take;
  logic        handshake;

  assign busy        = (state_q != ST_IDLE);
  assign req_valid   = (state_q == ST_REQ);
  assign handshake   = req_valid && req_ready;
  assign rsp_take    = (state_q == ST_WAIT) && rsp_valid;
  assign timeout_hit = busy && (int'(cnt_q) >= TIMEOUT_CYC - 1);
  assign rd_done     = rsp_take && !rsp_err && !req_we;
  assign fail        = (rsp_take && rsp_err) || (timeout_hit && !rsp_take && !handshake);
  assign fail_code   = rsp_take ? ERR_BADADDR : ERR_TIMEOUT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_size  <= '0;
      req_wdata <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q   <= ST_REQ;
          cnt_q     <= '0;
          req_we    <= start_we;
          req_addr  <= start_addr;
          req_size  <= start_size;
          req_wdata <= start_wdata;
        end
        ST_REQ: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (req_ready)        state_q <= ST_WAIT;
          else if (timeout_hit) state_q <= ST_IDLE;
        end
        ST_WAIT: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (rsp_valid || timeout_hit) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sba_master.sv
module sba_master
  import sba_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int DATA_W      = 128,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_we,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [2:0]        bus_req_size,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic              bus_rsp_err
);
  localparam int AW_WORDS = (ADDR_W + 31) / 32;
  localparam int DW_WORDS = DATA_W / 32;
  localparam logic [6:0] LAST_A = RA_ADDR0 + 7'(AW_WORDS - 1);
  localparam logic [6:0] LAST_D = RA_DATA0 + 7'(DW_WORDS - 1);
  localparam logic [4:0] CAPS   = width_caps(DATA_W);

  // configuration and status
  logic [2:0]        size_q;
  logic              autoinc_q, autoread_q, fresh_q;
  logic [2:0]        err_q;
  logic [DATA_W-1:0] data_q;

  // decode
  logic       hit_ctl, hit_addr, hit_data;
  logic [1:0] aidx, didx;
  logic       ctl_wr, addr_wr, data_wr, d0_wr, d0_rd, trig_wr;
  logic       err_block, eng_busy;

  assign hit_ctl   = (reg_addr == RA_CTL);
  assign hit_addr  = (reg_addr >= RA_ADDR0) && (reg_addr <= LAST_A);
  assign hit_data  = (reg_addr >= RA_DATA0) && (reg_addr <= LAST_D);
  assign aidx      = 2'(reg_addr - RA_ADDR0);
  assign didx      = 2'(reg_addr - RA_DATA0);
  assign ctl_wr    = reg_valid && reg_write && hit_ctl;
  assign addr_wr   = reg_valid && reg_write && hit_addr;
  assign data_wr   = reg_valid && reg_write && hit_data;
  assign d0_wr     = data_wr && (didx == 2'd0);
  assign d0_rd     = reg_valid && !reg_write && hit_data && (didx == 2'd0);
  assign trig_wr   = ctl_wr && reg_wdata[5];
  assign err_block = (err_q != ERR_NONE);

  // access outcome events
  logic busy_viol, stale_viol, ok_addr_wr, ok_data_wr, ok_d0_rd, ok_trig;
  assign busy_viol  = !err_block && eng_busy && (addr_wr || data_wr || d0_rd || trig_wr);
  assign stale_viol = !err_block && !eng_busy && d0_rd && !fresh_q;
  assign ok_addr_wr = addr_wr && !err_block && !eng_busy;
  assign ok_data_wr = data_wr && !err_block && !eng_busy;
  assign ok_d0_rd   = d0_rd && !err_block && !eng_busy && fresh_q;
  assign ok_trig    = trig_wr && !err_block && !eng_busy;
  assign reg_err    = (err_block && (addr_wr || data_wr || d0_rd)) || busy_viol || stale_viol;

  // address register
  logic [ADDR_W-1:0] addr_q, addr_merged, addr_stepped;
  logic              inc_en;

  // request selection
  logic [2:0]        eff_size;
  logic              want_rd, want_wr, want_any, req_legal, start, bad_req;
  logic [ADDR_W-1:0] start_addr;
  logic [DATA_W-1:0] start_wdata;

  always_comb begin
    eff_size = ctl_wr ? reg_wdata[2:0] : size_q;
    want_wr  = ok_data_wr && (didx == 2'd0);
    want_rd  = ok_trig || (ok_addr_wr && autoread_q) || (ok_d0_rd && autoread_q);
    want_any = want_rd || want_wr;
    if (ok_addr_wr)                 start_addr = addr_merged;
    else if (ok_d0_rd && autoinc_q) start_addr = addr_stepped;
    else                            start_addr = addr_q;
    start_wdata = data_q;
    start_wdata[31:0] = reg_wdata;
    req_legal = width_ok(eff_size, DATA_W) && addr_aligned(start_addr[6:0], eff_size);
    start     = want_any && req_legal;
    bad_req   = want_any && !req_legal;
    inc_en    = autoinc_q && ((want_wr && req_legal) || ok_d0_rd);
  end

  sba_addr_reg #(.ADDR_W(ADDR_W), .AW_WORDS(AW_WORDS)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (ok_addr_wr),
    .wr_idx       (aidx),
    .wr_word      (reg_wdata),
    .inc_en       (inc_en),
    .inc_code     (size_q),
    .addr_q       (addr_q),
    .addr_merged  (addr_merged),
    .addr_stepped (addr_stepped)
  );

  logic       rd_done, eng_fail;
  logic [2:0] eng_code;

  sba_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_we    (want_wr),
    .start_addr  (start_addr),
    .start_size  (eff_size),
    .start_wdata (start_wdata),
    .busy        (eng_busy),
    .req_valid   (bus_req_valid),
    .req_ready   (bus_req_ready),
    .req_we      (bus_req_we),
    .req_addr    (bus_req_addr),
    .req_size    (bus_req_size),
    .req_wdata   (bus_req_wdata),
    .rsp_valid   (bus_rsp_valid),
    .rsp_err     (bus_rsp_err),
    .rd_done     (rd_done),
    .fail        (eng_fail),
    .fail_code   (eng_code)
  );

  // state updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q     <= 3'd2;
      autoinc_q  <= 1'b0;
      autoread_q <= 1'b0;
      err_q      <= ERR_NONE;
      fresh_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      if (ctl_wr) begin
        size_q     <= reg_wdata[2:0];
        autoinc_q  <= reg_wdata[3];
        autoread_q <= reg_wdata[4];
      end
      // error field: write-one-to-clear, first code sticks
      if (err_q == ERR_NONE) begin
        if (eng_fail)                     err_q <= eng_code;
        else if (busy_viol || stale_viol) err_q <= ERR_BUSY;
        else if (bad_req)                 err_q <= ERR_OTHER;
      end else if (ctl_wr) begin
        err_q <= err_q & ~reg_wdata[8:6];
      end
      if (rd_done) begin
        data_q  <= bus_rsp_data;
        fresh_q <= 1'b1;
      end else if (ok_data_wr) begin
        data_q[didx*32 +: 32] <= reg_wdata;
        if (didx == 2'd0) fresh_q <= 1'b1;
      end else if (ok_d0_rd) begin
        fresh_q <= 1'b0;
      end
    end
  end

  // read mux
  logic [AW_WORDS*32-1:0] addr_pad;
  assign addr_pad = (AW_WORDS*32)'(addr_q);

  always_comb begin
    reg_rdata = '0;
    if (hit_ctl)
      reg_rdata = {10'd0, CAPS, 7'(ADDR_W), eng_busy, err_q, 1'b0, autoread_q, autoinc_q, size_q};
    else if (hit_addr)
      reg_rdata = addr_pad[aidx*32 +: 32];
    else if (hit_data)
      reg_rdata = data_q[didx*32 +: 32];
  end

endmodule

// File: rtl/sba_master_chk.sv
module sba_master_chk
  import sba_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int DATA_W      = 128,
  parameter int TIMEOUT_CYC = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [6:0]        reg_addr,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_req_we,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic [2:0]        bus_req_size,
  input logic [DATA_W-1:0] bus_req_wdata,
  input logic [2:0]        err_q,
  input logic              eng_busy,
  input logic              fresh_q
);
  logic ctl_wr;
  assign ctl_wr = reg_valid && reg_write && (reg_addr == RA_CTL);

  logic [31:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)        busy_run <= '0;
    else if (eng_busy) busy_run <= busy_run + 32'd1;
    else               busy_run <= '0;
  end

  // R3: a held-off request keeps its content
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> !bus_req_valid ||
      ($stable(bus_req_addr) && $stable(bus_req_we) && $stable(bus_req_wdata) && $stable(bus_req_size)));

  // R10: only aligned, supported requests reach the bus
  assert_req_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> width_ok(bus_req_size, DATA_W) && addr_aligned(bus_req_addr[6:0], bus_req_size));

  // R12: a non-zero code only changes through a control write
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != ERR_NONE) && !ctl_wr |=> $stable(err_q));

  // R12: nothing is issued while the error field is set
  assert_no_start_on_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != ERR_NONE) && !eng_busy |=> !bus_req_valid);

  // R13: a new request follows a register access one cycle earlier
  assert_start_follows_access_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) |-> $past(reg_valid));

  // R8: a refused stale read leaves code 4
  assert_stale_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write && (reg_addr == RA_DATA0) && !fresh_q && (err_q == ERR_NONE) && !eng_busy
      |=> err_q == ERR_BUSY);

  // R11: a transaction never outlives the timeout window
  assert_timeout_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 32'(TIMEOUT_CYC + 1));

endmodule

bind sba_master sba_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_valid     (reg_valid),
  .reg_write     (reg_write),
  .reg_addr      (reg_addr),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_req_we    (bus_req_we),
  .bus_req_addr  (bus_req_addr),
  .bus_req_size  (bus_req_size),
  .bus_req_wdata (bus_req_wdata),
  .err_q         (err_q),
  .eng_busy      (eng_busy),
  .fresh_q       (fresh_q)
);

// File: tb/sim_sba_master.sv
`timescale 1ns/1ps
module sim_sba_master;
  localparam int AW = 40;
  localparam int DW = 128;
  localparam int TO = 16;
  localparam real HALF = 10.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [6:0]  reg_addr = 7'h38;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        bus_req_valid, bus_req_we;
  logic        bus_req_ready;
  logic [AW-1:0] bus_req_addr;
  logic [2:0]  bus_req_size;
  logic [DW-1:0] bus_req_wdata;
  logic        bus_rsp_valid = 1'b0;
  logic [DW-1:0] bus_rsp_data = '0;
  logic        bus_rsp_err = 1'b0;

  always #(HALF) clk = ~clk;

  sba_master #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_we(bus_req_we),
    .bus_req_addr(bus_req_addr), .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data), .bus_rsp_err(bus_rsp_err));

  // memory model and responder
  logic [7:0] mem [256];
  logic       stall = 1'b0;
  int         lat = 0;
  int         req_count = 0;
  logic       pend = 1'b0;
  int         wait_n = 0;
  logic       pend_err = 1'b0;
  logic [DW-1:0] pend_data = '0;
  logic [AW-1:0] rec_addr = '0;
  logic        rec_we = 1'b0;
  logic [2:0]  rec_size = '0;

  assign bus_req_ready = !stall;

  always @(negedge clk) begin
    if (bus_rsp_valid) bus_rsp_valid = 1'b0;
    if (pend) begin
      if (wait_n == 0) begin
        bus_rsp_valid = 1'b1;
        bus_rsp_data  = pend_data;
        bus_rsp_err   = pend_err;
        pend = 1'b0;
      end else wait_n--;
    end
    if (bus_req_valid && bus_req_ready) begin
      req_count++;
      rec_addr = bus_req_addr;
      rec_we   = bus_req_we;
      rec_size = bus_req_size;
      pend_err = (bus_req_addr >= AW'(32'h0010_0000));
      pend_data = '0;
      if (!pend_err) begin
        for (int i = 0; i < (1 << bus_req_size); i++) begin
          if (bus_req_we) mem[8'(bus_req_addr + AW'(i))] = bus_req_wdata[8*i +: 8];
          else            pend_data[8*i +: 8] = mem[8'(bus_req_addr + AW'(i))];
        end
      end
      pend = 1'b1;
      wait_n = lat;
    end
  end

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [6:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic e);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = d;
    #1;
    rd = reg_rdata; e = reg_err;
    @(posedge clk);
    #1;
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    access(1'b1, a, d, r, e);
  endtask

  task automatic peek(input logic [6:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      peek(7'h38, v);
      if (!v[9]) break;
    end
  endtask

  function automatic logic [31:0] cfg(input int sz, input bit ai, input bit ar, input bit sr, input int clr);
    return 32'(sz) | (32'(ai) << 3) | (32'(ar) << 4) | (32'(sr) << 5) | (32'(clr) << 6);
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] v, r;
    logic e;
    logic [127:0] pat, act, mask;
    int nb, rc;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 5);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of the control word
    peek(7'h38, v);
    chk("R1 reset control", 128'(v), 128'(32'd2 | (32'd40 << 10) | (32'h1F << 17)));
    chk("R1 bus idle after reset", 128'(bus_req_valid), 128'(0));

    // R2 address words, bits above ADDR_W read 0
    wr(7'h39, 32'hDEAD_BEE0); wr(7'h3A, 32'hFFFF_FF12);
    access(1'b0, 7'h39, 0, r, e); chk("R2 addr word0", 128'(r), 128'(32'hDEAD_BEE0));
    access(1'b0, 7'h3A, 0, r, e); chk("R2 addr word1 truncated", 128'(r), 128'(32'h12));
    access(1'b0, 7'h3B, 0, r, e); chk("R2 absent addr word", 128'(r), 128'(0));
    wr(7'h3A, 0);

    // sweep over every width code: store, step, load back
    for (int sz = 0; sz < 5; sz++) begin
      nb = 1 << sz;
      lat = (sz % 2) * 3;
      pat = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0 ^ 128'(sz * 32'h01010101);
      mask = (nb == 16) ? '1 : ((128'(1) << (8 * nb)) - 128'(1));
      for (int i = 0; i < 16; i++) mem[8'h40 + i] = 8'h00;
      wr(7'h38, cfg(sz, 1, 0, 0, 0));
      wr(7'h39, 32'h40);
      wr(7'h3D, pat[63:32]); wr(7'h3E, pat[95:64]); wr(7'h3F, pat[127:96]);
      rc = req_count;
      wr(7'h3C, pat[31:0]);
      wait_idle();
      chk("R3 one store request", 128'(req_count - rc), 128'(1));
      chk("R3 store fields", {rec_we, rec_size, 40'(rec_addr)}, {1'b1, 3'(sz), 40'h40});
      act = '0;
      for (int i = 0; i < 16; i++) act[8*i +: 8] = mem[8'h40 + i];
      chk("R3 stored bytes", act, pat & mask);
      access(1'b0, 7'h39, 0, r, e);
      chk("R4 step after store", 128'(r), 128'(32'h40 + nb));
      wr(7'h39, 32'h40);
      wr(7'h38, cfg(sz, 1, 0, 1, 0));
      wait_idle();
      peek(7'h38, v);
      chk("R5 trigger bit reads 0", 128'(v[5]), 128'(0));
      chk("R5 load fields", {rec_we, rec_size, 40'(rec_addr)}, {1'b0, 3'(sz), 40'h40});
      act = '0;
      for (int w = 3; w >= 0; w--) begin
        access(1'b0, 7'(7'h3C + w), 0, r, e);
        act[32*w +: 32] = r;
      end
      chk("R5 R7 loaded data", act, pat & mask);
      access(1'b0, 7'h39, 0, r, e);
      chk("R4 R7 step after read", 128'(r), 128'(32'h40 + nb));
    end
    lat = 1;

    // R6 and R7: streaming loads
    wr(7'h3A, 0);
    wr(7'h38, cfg(2, 1, 1, 0, 0));
    wr(7'h39, 32'h80);
    wait_idle();
    chk("R6 fetch on address write", {rec_we, 40'(rec_addr)}, {1'b0, 40'h80});
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 7'h3C, 0, r, e);
      chk("R7 streamed word", {e, r}, {1'b0, mem[8'h83 + 4*k], mem[8'h82 + 4*k], mem[8'h81 + 4*k], mem[8'h80 + 4*k]});
      wait_idle();
    end
    chk("R7 fetch at stepped address", 128'(rec_addr), 128'(32'h90));

    // R8 stale read
    wr(7'h38, cfg(2, 1, 0, 0, 0));
    access(1'b0, 7'h3C, 0, r, e);
    chk("R8 fresh read accepted", {e, r}, {1'b0, mem[8'h93], mem[8'h92], mem[8'h91], mem[8'h90]});
    rc = req_count;
    access(1'b0, 7'h3C, 0, r, e);
    chk("R8 stale read flagged", 128'(e), 128'(1));
    peek(7'h38, v);
    chk("R8 stale code", 128'(v[8:6]), 128'(4));
    access(1'b0, 7'h39, 0, r, e);
    chk("R8 no step on stale read", 128'(r), 128'(32'h94));

    // R12 sticky error blocks activity
    wr(7'h39, 32'h20);
    access(1'b0, 7'h39, 0, r, e);
    chk("R12 address write dropped", 128'(r), 128'(32'h94));
    access(1'b1, 7'h39, 32'h20, r, e);
    chk("R12 access flagged", 128'(e), 128'(1));
    wr(7'h38, cfg(2, 1, 0, 1, 0));
    repeat (4) @(negedge clk);
    chk("R12 no request while error", 128'(req_count - rc), 128'(0));
    peek(7'h38, v);
    chk("R12 code kept", 128'(v[8:6]), 128'(4));
    wr(7'h38, cfg(2, 0, 0, 0, 7));
    peek(7'h38, v);
    chk("R12 write-one clear", 128'(v[8:6]), 128'(0));

    // R9 and R13: access while busy
    stall = 1'b1;
    wr(7'h39, 32'h80);
    wr(7'h38, cfg(2, 0, 0, 1, 0));
    peek(7'h38, v);
    chk("R13 busy after trigger", {v[9], bus_req_valid}, {1'b1, 1'b1});
    access(1'b1, 7'h39, 32'h44, r, e);
    chk("R9 busy access flagged", 128'(e), 128'(1));
    peek(7'h38, v);
    chk("R9 busy code", 128'(v[8:6]), 128'(4));
    access(1'b0, 7'h39, 0, r, e);
    chk("R9 address unchanged", 128'(r), 128'(32'h80));
    stall = 1'b0;
    wait_idle();
    peek(7'h38, v);
    chk("R13 idle after response", 128'(v[9]), 128'(0));
    wr(7'h38, cfg(2, 0, 0, 0, 7));

    // R10 misaligned and unsupported width
    rc = req_count;
    wr(7'h39, 32'h82);
    wr(7'h38, cfg(2, 0, 0, 1, 0));
    repeat (3) @(negedge clk);
    peek(7'h38, v);
    chk("R10 misaligned", {v[9], v[8:6]}, {1'b0, 3'd3});
    wr(7'h38, cfg(2, 0, 0, 0, 7));
    wr(7'h39, 32'h80);
    wr(7'h38, cfg(5, 0, 0, 1, 0));
    repeat (3) @(negedge clk);
    peek(7'h38, v);
    chk("R10 unsupported width", 128'(v[8:6]), 128'(3));
    chk("R10 nothing issued", 128'(req_count - rc), 128'(0));
    wr(7'h38, cfg(2, 0, 0, 0, 7));

    // R11 error response, first error kept
    wr(7'h39, 32'h0010_0000);
    wr(7'h38, cfg(2, 0, 0, 1, 0));
    wait_idle();
    peek(7'h38, v);
    chk("R11 response error", 128'(v[8:6]), 128'(2));
    access(1'b0, 7'h3C, 0, r, e);
    peek(7'h38, v);
    chk("R12 first code kept", {e, v[8:6]}, {1'b1, 3'd2});
    wr(7'h38, cfg(2, 0, 0, 0, 7));

    // R11 timeout
    stall = 1'b1;
    wr(7'h39, 32'h80);
    wr(7'h38, cfg(2, 0, 0, 1, 0));
    repeat (TO - 1) @(posedge clk);
    #1 peek(7'h38, v);
    chk("R11 busy before timeout", 128'(v[9]), 128'(1));
    @(posedge clk);
    #1 peek(7'h38, v);
    chk("R11 timeout", {v[9], v[8:6]}, {1'b0, 3'd1});
    stall = 1'b0;
    wr(7'h38, cfg(2, 0, 0, 0, 7));
    peek(7'h38, v);
    chk("R12 cleared after timeout", 128'(v[8:6]), 128'(0));

    report();
    $finish;
  end
endmodule